// File: doc/BRIEF.md
# SPI Slave with Select Framing

This block is the receiving end of a four-wire serial link, clocked by a fast system clock. The serial clock, select and data-in pins are brought into the system clock domain through flop chains. Their edges are found by comparing each synchronised level with its previous value. The block samples the incoming data line and drives the outgoing one in any of the four polarity and phase combinations. Bits travel most significant first, or least significant first when asked.

On the local side, one byte can wait in a holding register while another sits in the shifter, and a single receive register keeps the last complete byte. A flag says when the holding register can take a new byte. A second flag says when a received byte is waiting. The select line frames every byte. In phase-0 mode the master must release select between bytes. In phase-1 mode select may stay low across a stream of bytes.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset, tx_empty is 1, rx_full is 0, rx_data is 0 and miso_o is 0.
- R2: A tx_wr pulse while tx_empty is 1 stores tx_data and clears tx_empty. The byte moves into the shifter as soon as the shifter holds nothing and no byte is in progress, and tx_empty then returns to 1. A tx_wr pulse while tx_empty is 0 is ignored.
- R3: With cpha 0, bit 1 of the shifter byte appears on miso_o once select is low, before any clock edge. Data is sampled on each leading clock edge and miso_o moves to the next bit on each trailing edge.
- R4: With cpha 1, miso_o stays 0 until the first leading edge of a byte. Each leading edge drives the next bit and each trailing edge samples. Bytes may follow each other while select stays low, and the first leading edge of each byte starts its bit 1.
- R5: With cpha 0, once eight bits are complete, further clock edges are ignored until select has gone high and low again. miso_o stays 0 during that time and no byte is received.
- R6: After the eighth sample, the received byte is written to rx_data and rx_full rises. An rx_rd pulse clears rx_full.
- R7: If a byte completes while rx_full is 1, the new byte is dropped, rx_data keeps the older byte, and no other output shows it.
- R8: With lsb_first 0, bits travel MSB first. With lsb_first 1, they travel LSB first, in both directions.
- R9: Select rising mid-byte aborts the byte. rx_full does not rise, the bit count starts over, and the shifter keeps its byte so it is sent whole in the next framed byte.
- R10: cpol gives the idle clock level. The leading edge is the one that leaves idle.
- R11: miso_o is 0 while select is high.
- R12: A byte that starts with an empty shifter sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0: sample on leading edge; 1: drive on leading edge |
| lsb_first | input | 1 | 1 selects least significant bit first |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| ss_n_i | input | 1 | Select from the master, active low (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| miso_o | output | 1 | Serial data to the master |
| tx_data | input | DATA_W | Byte to queue for sending |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_empty | output | 1 | Holding register can take a byte |
| rx_data | output | DATA_W | Last received byte |
| rx_rd | input | 1 | Acknowledge of rx_data; clears rx_full |
| rx_full | output | 1 | A received byte is waiting |

## Verification
The hardest cases to reach from the ports are the dropped byte on overrun and the byte kept in the shifter after an abort. Both need the master to act while local-side state is in a particular condition. To get there, the bench turns off its automatic reader, clocks two full bytes so that the second meets a full receive register, and only then re-enables the reader to prove the first byte survived. For the abort, it raises select after three bit times, then frames a full byte and compares what arrives on the data-out line with the byte queued before the abort.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

   // Position in the byte of the bit handled at step cnt of a transfer.
   function automatic int unsigned step_to_bit(input int unsigned cnt,
                                               input logic lsb,
                                               input int unsigned width);
      return lsb ? cnt : (width - 1 - cnt);
   endfunction

   typedef enum logic [1:0] {
      PIN_SCK  = 2'd2,
      PIN_SSN  = 2'd1,
      PIN_MOSI = 2'd0
   } pin_slot_e;

endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_sel_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stg
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stg[s-1].r;
         end
      end
   end

   assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/spi_sel_txbuf.sv
module spi_sel_txbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_wr,
   input  logic              busy,
   input  logic              consume,
   output logic [DATA_W-1:0] sh_word,
   output logic              tx_empty
);

   logic [DATA_W-1:0] hold_q;
   logic              hold_v;
   logic              sh_v;
   logic              take;
   logic              load;

   always_comb begin
      take = tx_wr & ~hold_v;
      load = hold_v & ~sh_v & ~busy & ~consume;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         hold_v  <= 1'b0;
         sh_word <= '0;
         sh_v    <= 1'b0;
      end else begin
         if (take) begin
            hold_q <= tx_data;
            hold_v <= 1'b1;
         end
         if (consume) begin
            sh_word <= '0;
            sh_v    <= 1'b0;
         end else if (load) begin
            sh_word <= hold_q;
            sh_v    <= 1'b1;
            hold_v  <= 1'b0;
         end
      end
   end

   assign tx_empty = ~hold_v;

endmodule

// File: rtl/spi_sel_engine.sv
module spi_sel_engine
   import spi_sel_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              lsb_first,
   input  logic              sck_s,
   input  logic              ss_n_s,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] tx_word,
   output logic              miso_o,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_done,
   output logic              busy
);

   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

   logic              sck_q;
   logic [CNT_W-1:0]  cnt;
   logic              started;
   logic              wait_hi;
   logic              inflight;
   logic [DATA_W-1:0] rx_sh;
   logic [DATA_W-1:0] rx_next;
   logic [CNT_W-1:0]  idx;
   logic              sel, chg, lead, trail, last, samp, adv;

   always_comb begin
      sel   = ~ss_n_s;
      chg   = sck_s ^ sck_q;
      lead  = chg & (sck_s ^ cpol);
      trail = chg & ~(sck_s ^ cpol);
      last  = (cnt == LAST_STEP);
      idx   = CNT_W'(step_to_bit(int'(cnt), lsb_first, DATA_W));
      rx_next      = rx_sh;
      rx_next[idx] = mosi_s;
      if (cpha) begin
         samp = sel & started & trail;
         adv  = 1'b0;
      end else begin
         samp = sel & ~wait_hi & lead;
         adv  = sel & ~wait_hi & inflight & trail & ~last;
      end
      if (cpha) miso_o = started & tx_word[idx];
      else      miso_o = sel & ~wait_hi & tx_word[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q    <= 1'b0;
         cnt      <= '0;
         started  <= 1'b0;
         wait_hi  <= 1'b0;
         inflight <= 1'b0;
         rx_sh    <= '0;
         rx_word  <= '0;
         rx_done  <= 1'b0;
      end else begin
         sck_q   <= sck_s;
         rx_done <= 1'b0;
         if (!sel) begin
            cnt      <= '0;
            started  <= 1'b0;
            wait_hi  <= 1'b0;
            inflight <= 1'b0;
         end else if (cpha) begin
            if (lead) begin
               started  <= 1'b1;
               inflight <= 1'b1;
               if (started) cnt <= cnt + 1'b1;
            end
            if (samp) begin
               rx_sh <= rx_next;
               if (last) begin
                  cnt      <= '0;
                  started  <= 1'b0;
                  inflight <= 1'b0;
                  rx_done  <= 1'b1;
                  rx_word  <= rx_next;
               end
            end
         end else begin
            if (samp) begin
               rx_sh    <= rx_next;
               inflight <= 1'b1;
               if (last) begin
                  cnt      <= '0;
                  wait_hi  <= 1'b1;
                  inflight <= 1'b0;
                  rx_done  <= 1'b1;
                  rx_word  <= rx_next;
               end
            end
            if (adv) cnt <= cnt + 1'b1;
         end
      end
   end

   assign busy = inflight;

endmodule

// File: rtl/spi_sel_rxbuf.sv
module spi_sel_rxbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
      end else begin
         if (rx_rd) rx_full <= 1'b0;
         if (rx_done && !rx_full) begin
            rx_data <= rx_word;
            rx_full <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
   import spi_sel_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              lsb_first,
   input  logic              sck_i,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_wr,
   output logic              tx_empty,
   output logic [DATA_W-1:0] rx_data,
   input  logic              rx_rd,
   output logic              rx_full
);

   localparam int         PIN_N   = 3;
   localparam logic [2:0] PIN_RST = 3'b010;

   if (DATA_W < 2) begin : g_bad_width
      $error("spi_sel_slave: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("spi_sel_slave: SYNC_STAGES must be at least 2");
   end

   logic [PIN_N-1:0]  pins_raw;
   logic [PIN_N-1:0]  pins_s;
   logic [DATA_W-1:0] sh_word;
   logic [DATA_W-1:0] rx_word;
   logic              rx_done;
   logic              busy;

   always_comb begin
      pins_raw           = '0;
      pins_raw[PIN_SCK]  = sck_i;
      pins_raw[PIN_SSN]  = ss_n_i;
      pins_raw[PIN_MOSI] = mosi_i;
   end

   spi_sel_sync #(
      .WIDTH   (PIN_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pins_raw),
      .q     (pins_s)
   );

   spi_sel_txbuf #(.DATA_W(DATA_W)) u_txbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_data  (tx_data),
      .tx_wr    (tx_wr),
      .busy     (busy),
      .consume  (rx_done),
      .sh_word  (sh_word),
      .tx_empty (tx_empty)
   );

   spi_sel_engine #(.DATA_W(DATA_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpol      (cpol),
      .cpha      (cpha),
      .lsb_first (lsb_first),
      .sck_s     (pins_s[PIN_SCK]),
      .ss_n_s    (pins_s[PIN_SSN]),
      .mosi_s    (pins_s[PIN_MOSI]),
      .tx_word   (sh_word),
      .miso_o    (miso_o),
      .rx_word   (rx_word),
      .rx_done   (rx_done),
      .busy      (busy)
   );

   spi_sel_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_done (rx_done),
      .rx_word (rx_word),
      .rx_rd   (rx_rd),
      .rx_data (rx_data),
      .rx_full (rx_full)
   );

endmodule

// File: rtl/spi_sel_slave_chk.sv
module spi_sel_slave_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_wr,
   input logic              tx_empty,
   input logic              rx_rd,
   input logic              rx_full,
   input logic [DATA_W-1:0] rx_data,
   input logic              rx_done,
   input logic              ss_n_i,
   input logic              miso_o
);

   p_tx_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_wr && tx_empty |=> !tx_empty);

   p_tx_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_empty) |-> $past(tx_wr));

   p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(rx_done));

   p_rx_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rd && !rx_done |=> !rx_full);

   p_rx_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full && !rx_rd |=> rx_full && $stable(rx_data));

   p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2) |-> !miso_o);

endmodule

bind spi_sel_slave spi_sel_slave_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_wr    (tx_wr),
   .tx_empty (tx_empty),
   .rx_rd    (rx_rd),
   .rx_full  (rx_full),
   .rx_data  (rx_data),
   .rx_done  (rx_done),
   .ss_n_i   (ss_n_i),
   .miso_o   (miso_o)
);

// File: tb/spi_sel_slave_bench.sv
`timescale 1ns/1ps
module spi_sel_slave_bench;

   localparam int HP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
   logic       sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
   logic       miso;
   logic [7:0] tx_data = 8'h00;
   logic       tx_wr = 1'b0;
   logic       tx_empty;
   logic [7:0] rx_data;
   logic       rx_rd = 1'b0;
   logic       rx_full;
   logic       mon_en = 1'b1;

   int vectors = 0;
   int miscmp  = 0;
   logic [7:0] exp_q[$];

   always #4 clk = ~clk;

   spi_sel_slave u_spi_sel_slave (
      .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .lsb_first(lsb),
      .sck_i(sck), .ss_n_i(ss_n), .mosi_i(mosi), .miso_o(miso),
      .tx_data(tx_data), .tx_wr(tx_wr), .tx_empty(tx_empty),
      .rx_data(rx_data), .rx_rd(rx_rd), .rx_full(rx_full)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscmp++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_tx(input logic [7:0] b);
      @(negedge clk);
      tx_data = b;
      tx_wr   = 1'b1;
      @(negedge clk);
      tx_wr   = 1'b0;
   endtask

   // Master side: clocks nbits bits, returns what came back on miso.
   task automatic spi_byte(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
      mi = 8'h00;
      for (int i = 0; i < nbits; i++) begin
         int p = lsb ? i : 7 - i;
         if (!cpha) begin
            mosi = mo[p];
            wait_clk(HP);
            mi[p] = miso;
            sck = ~cpol;
            wait_clk(HP);
            sck = cpol;
         end else begin
            sck  = ~cpol;
            mosi = mo[p];
            wait_clk(HP);
            mi[p] = miso;
            sck = cpol;
            wait_clk(HP);
         end
      end
      wait_clk(HP);
   endtask

   // Scoreboard monitor: reads each received byte and compares it.
   always @(negedge clk) begin
      if (rx_rd) rx_rd = 1'b0;
      else if (mon_en && rx_full) begin
         if (exp_q.size() == 0) begin
            vectors++;
            miscmp++;
            $display("FAIL R6 unexpected byte actual=%0h expected=none", rx_data);
         end else begin
            chk("R6 received byte", {24'h0, rx_data}, {24'h0, exp_q.pop_front()});
         end
         rx_rd = 1'b1;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      vectors++;
      miscmp++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end

   initial begin
      logic [7:0] mi;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      // R1 reset state
      chk("R1 tx_empty", {31'h0, tx_empty}, 32'h1);
      chk("R1 rx_full",  {31'h0, rx_full},  32'h0);
      chk("R1 rx_data",  {24'h0, rx_data},  32'h0);
      chk("R1 miso",     {31'h0, miso},     32'h0);

      // R2 holding register and shifter
      push_tx(8'hA5);
      wait_clk(4);
      chk("R2 moved to shifter", {31'h0, tx_empty}, 32'h1);
      push_tx(8'h3C);
      wait_clk(4);
      chk("R2 held while shifter full", {31'h0, tx_empty}, 32'h0);
      push_tx(8'hFF);
      wait_clk(2);
      chk("R2 write ignored when full", {31'h0, tx_empty}, 32'h0);
      chk("R11 miso idle", {31'h0, miso}, 32'h0);

      // R3 cpha 0, cpol 0, MSB first
      exp_q.push_back(8'h96);
      ss_n = 1'b0;
      wait_clk(HP);
      chk("R3 first bit before edge", {31'h0, miso}, 32'h1);
      spi_byte(8'h96, 8, mi);
      chk("R3 miso byte", {24'h0, mi}, 32'hA5);
      // R5 extra clocks with select still low
      spi_byte(8'h11, 8, mi);
      chk("R5 miso quiet", {24'h0, mi}, 32'h00);
      chk("R5 no byte received", {31'h0, rx_full}, 32'h0);
      ss_n = 1'b1;
      wait_clk(6);
      chk("R2 next byte moved", {31'h0, tx_empty}, 32'h1);
      chk("R11 miso after release", {31'h0, miso}, 32'h0);
      exp_q.push_back(8'h5A);
      ss_n = 1'b0;
      wait_clk(HP);
      spi_byte(8'h5A, 8, mi);
      chk("R3 second framed byte", {24'h0, mi}, 32'h3C);
      ss_n = 1'b1;
      wait_clk(6);

      // R4 and R10: cpha 1, cpol 1, bytes back to back
      cpol = 1'b1; cpha = 1'b1; sck = 1'b1;
      wait_clk(6);
      push_tx(8'hC3);
      wait_clk(4);
      push_tx(8'h81);
      wait_clk(4);
      chk("R4 second byte queued", {31'h0, tx_empty}, 32'h0);
      ss_n = 1'b0;
      wait_clk(HP);
      chk("R4 miso before first edge", {31'h0, miso}, 32'h0);
      exp_q.push_back(8'h12);
      exp_q.push_back(8'h34);
      spi_byte(8'h12, 8, mi);
      chk("R10 cpol1 byte one", {24'h0, mi}, 32'hC3);
      spi_byte(8'h34, 8, mi);
      chk("R4 byte two select held", {24'h0, mi}, 32'h81);
      ss_n = 1'b1;
      wait_clk(6);

      // R8 LSB first, cpha 0, cpol 0
      cpol = 1'b0; cpha = 1'b0; lsb = 1'b1; sck = 1'b0;
      wait_clk(6);
      push_tx(8'h01);
      wait_clk(4);
      exp_q.push_back(8'h0B);
      ss_n = 1'b0;
      wait_clk(HP);
      spi_byte(8'h0B, 8, mi);
      chk("R8 lsb first miso", {24'h0, mi}, 32'h01);
      ss_n = 1'b1;
      wait_clk(6);
      lsb = 1'b0;

      // R9 abort mid-byte
      push_tx(8'h77);
      wait_clk(4);
      ss_n = 1'b0;
      wait_clk(HP);
      spi_byte(8'hFF, 3, mi);
      ss_n = 1'b1;
      wait_clk(8);
      chk("R9 no byte after abort", {31'h0, rx_full}, 32'h0);
      exp_q.push_back(8'hE1);
      ss_n = 1'b0;
      wait_clk(HP);
      spi_byte(8'hE1, 8, mi);
      chk("R9 shifter byte resent", {24'h0, mi}, 32'h77);
      ss_n = 1'b1;
      wait_clk(8);

      // R7 and R12: overrun with an empty shifter, cpha 1
      mon_en = 1'b0;
      cpha = 1'b1;
      wait_clk(4);
      ss_n = 1'b0;
      wait_clk(HP);
      spi_byte(8'h11, 8, mi);
      chk("R12 empty shifter sends zero", {24'h0, mi}, 32'h00);
      wait_clk(6);
      chk("R6 rx_full set", {31'h0, rx_full}, 32'h1);
      chk("R6 rx_data", {24'h0, rx_data}, 32'h11);
      spi_byte(8'h22, 8, mi);
      wait_clk(6);
      chk("R7 old byte kept", {24'h0, rx_data}, 32'h11);
      chk("R7 rx_full stays", {31'h0, rx_full}, 32'h1);
      ss_n = 1'b1;
      exp_q.push_back(8'h11);
      mon_en = 1'b1;
      wait_clk(10);
      chk("R6 rx_full cleared by read", {31'h0, rx_full}, 32'h0);
      chk("R6 all bytes seen", exp_q.size(), 32'h0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   end

endmodule